// File: doc/BRIEF.md
# MOESI Snooping Cache Coherence Controller

This block keeps a small direct-mapped private cache coherent with its peers on a shared snooping bus. It tracks five coherence states per line. The processor side takes read, write and evict requests. The bus side does two jobs. It issues read, read-for-ownership and upgrade transactions for this cache. It also answers the same transactions when other caches issue them, by driving a wired "present" response and, when it holds dirty data, supplying that data straight to the requester.

The Owned state is what sets this controller apart. A dirty line that another cache reads is handed over cache-to-cache and stays dirty here. It is not first written back to memory. This cache then serves every later reader until the line is evicted or invalidated. Memory sees a write-back only when a dirty line leaves the cache.

A system places one instance per cache. The surrounding bus logic routes each issued transaction to the snoop ports of the other instances. It then returns fill data taken from a supplying peer if there is one, and from memory otherwise. It also returns the OR of the peers' present responses.

Top module: `moesi_line_ctrl`

## Requirements
- R1: Every line is in one of five states, encoded Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4. Reset leaves all lines Invalid. `line_state` shows the state of the line that `cpu_addr` names, or 0 when that line holds another tag.
- R2: A read miss issues a bus read (cmd 0). The line fills in Exclusive when `bus_shared` is low at completion and in Shared when it is high, and the fill data comes from `bus_rdata`.
- R3: A write to an Exclusive line completes as a hit, moves the line to Modified and issues no bus transaction.
- R4: A snooped bus read of a Modified line raises `snp_supply` with the line data and moves the line to Owned, with no write-back. The requesting cache installs the line in Shared.
- R5: An Owned line supplies the data on every snooped bus read and stays Owned.
- R6: Evicting a Modified or Owned line pulses `wb_valid` one cycle later with that line's address and data, and leaves the line Invalid. Evicting a Shared or Exclusive line, or a line not present, issues no write-back.
- R7: A snooped bus read of an Exclusive line moves it to Shared. A Shared holder raises `snp_shared` but never `snp_supply`.
- R8: A write to a Shared or Owned line issues an upgrade (cmd 2) and then completes in Modified. A Shared peer goes Invalid.
- R9: A snooped read-for-ownership (cmd 1) or upgrade (cmd 2) makes a Modified or Owned holder supply its data and go Invalid. A Shared or Exclusive holder goes Invalid without supplying.
- R10: A write miss issues a read-for-ownership (cmd 1) and ends in Modified with the written data. A miss whose target slot holds a dirty line of another tag writes that line back and invalidates it as the bus request starts.
- R11: A hit completes in the cycle it is presented, and `cpu_rdata` then holds the line data. While the request waits on the bus, `cpu_stall` stays high and `cpu_hit` low. Operation codes are read=0, write=1, evict=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present, held until hit |
| cpu_op | input | 2 | Request kind: read=0, write=1, evict=2 |
| cpu_addr | input | ADDR_W | Request address (index in low bits) |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Data of the addressed slot |
| cpu_hit | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request present but not complete |
| line_state | output | 3 | Coherence state of the addressed line |
| bus_req_valid | output | 1 | This cache has a bus transaction pending |
| bus_req_cmd | output | 2 | read=0, read-for-ownership=1, upgrade=2 |
| bus_req_addr | output | ADDR_W | Address of the pending transaction |
| bus_done | input | 1 | Pending transaction completes this cycle |
| bus_shared | input | 1 | Some peer reported holding the line |
| bus_rdata | input | DATA_W | Fill data for the completing transaction |
| wb_valid | output | 1 | Write-back to memory strobe |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back data |
| snp_valid | input | 1 | A peer's transaction is being snooped |
| snp_cmd | input | 2 | Snooped command, same codes as bus_req_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies the snooped data |
| snp_data | output | DATA_W | Supplied data |

## Verification
The bench builds two instances with the default parameters: 8-bit addresses, 16-bit data and four lines. They are joined by a modelled bus and a 256-word memory. With only four slots, addresses 0x10 and 0x14 collide in slot 0. This makes dirty-victim write-back and tag-mismatch lookups easy to reach. The two caches pass one line through every state pair the requirements name, including Owned serving repeated readers, ownership lost to an upgrade and Shared holders that keep quiet while memory supplies.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_state_e;

    typedef enum logic [1:0] {
        OP_RD = 2'd0,
        OP_WR = 2'd1,
        OP_EV = 2'd2
    } cpu_op_e;

    typedef enum logic [1:0] {
        BUS_RD  = 2'd0,
        BUS_RDX = 2'd1,
        BUS_UPG = 2'd2
    } bus_cmd_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUS  = 1'b1
    } phase_e;

    // Dirty lines are the ones memory does not mirror.
    function automatic logic is_dirty(line_state_e s);
        return (s == ST_M) || (s == ST_O);
    endfunction

    // State a held line takes when a peer's transaction is snooped.
    function automatic line_state_e snoop_next(line_state_e s, bus_cmd_e c);
        if (c == BUS_RD) begin
            case (s)
                ST_M:    return ST_O;
                ST_E:    return ST_S;
                default: return s;
            endcase
        end
        return ST_I;
    endfunction

    // State a line takes when this cache's own transaction completes.
    function automatic line_state_e fill_state(bus_cmd_e c, logic peers_hold);
        if (c == BUS_RD) return peers_hold ? ST_S : ST_E;
        return ST_M;
    endfunction

endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
    import moesi_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output line_state_e       rd_state,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  sn_idx,
    output line_state_e       sn_state,
    output logic [TAG_W-1:0]  sn_tag,
    output logic [DATA_W-1:0] sn_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_state_e       wr_state,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              su_en,
    input  logic [IDX_W-1:0]  su_idx,
    input  line_state_e       su_state
);

    typedef struct packed {
        line_state_e       st;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slots [NLINES];

    for (genvar i = 0; i < NLINES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '{st: ST_I, tag: '0, data: '0};
            end else if (su_en && su_idx == IDX_W'(i)) begin
                // snooped transitions take precedence over local updates
                slots[i].st <= su_state;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                slots[i] <= '{st: wr_state, tag: wr_tag, data: wr_data};
            end
        end
    end

    assign rd_state = slots[rd_idx].st;
    assign rd_tag   = slots[rd_idx].tag;
    assign rd_data  = slots[rd_idx].data;
    assign sn_state = slots[sn_idx].st;
    assign sn_tag   = slots[sn_idx].tag;
    assign sn_data  = slots[sn_idx].data;

endmodule

// File: rtl/moesi_snoop_resp.sv
module moesi_snoop_resp
    import moesi_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_state_e       sn_state,
    input  logic [TAG_W-1:0]  sn_tag,
    input  logic [DATA_W-1:0] sn_data,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data,
    output logic              su_en,
    output line_state_e       su_state
);

    logic holds;

    always_comb begin
        holds      = snp_valid && (sn_state != ST_I) && (sn_tag == snp_tag);
        snp_shared = holds;
        snp_supply = holds && is_dirty(sn_state);
        snp_data   = snp_supply ? sn_data : '0;
        su_en      = holds;
        su_state   = snoop_next(sn_state, bus_cmd_e'(snp_cmd));
    end

endmodule

// File: rtl/moesi_req_ctrl.sv
module moesi_req_ctrl
    import moesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int NLINES = 4,
    localparam int IDX_W = $clog2(NLINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_stall,
    output logic [2:0]        line_state,
    input  line_state_e       rd_state,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] rd_data,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_done,
    input  logic              bus_shared,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output line_state_e       wr_state,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data
);

    phase_e   phase_q;
    bus_cmd_e cmd_q;
    logic     start, wb_fire, match;
    bus_cmd_e start_cmd;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;

    always_comb begin
        idx       = cpu_addr[IDX_W-1:0];
        tag       = cpu_addr[ADDR_W-1:IDX_W];
        match     = (rd_state != ST_I) && (rd_tag == tag);
        cpu_rdata = rd_data;
        cpu_hit   = 1'b0;
        start     = 1'b0;
        start_cmd = BUS_RD;
        wb_fire   = 1'b0;
        wr_en     = 1'b0;
        wr_idx    = idx;
        wr_tag    = tag;
        wr_state  = rd_state;
        wr_data   = rd_data;

        if (phase_q == PH_BUS) begin
            if (bus_done) begin
                wr_en    = 1'b1;
                wr_state = fill_state(cmd_q, bus_shared);
                wr_data  = (cmd_q == BUS_UPG) ? rd_data : bus_rdata;
            end
        end else if (cpu_valid) begin
            case (cpu_op_e'(cpu_op))
                OP_RD: begin
                    if (match) cpu_hit = 1'b1;
                    else begin
                        start     = 1'b1;
                        start_cmd = BUS_RD;
                    end
                end
                OP_WR: begin
                    if (match && (rd_state == ST_M || rd_state == ST_E)) begin
                        cpu_hit  = 1'b1;
                        wr_en    = 1'b1;
                        wr_state = ST_M;
                        wr_data  = cpu_wdata;
                    end else begin
                        start     = 1'b1;
                        start_cmd = match ? BUS_UPG : BUS_RDX;
                    end
                end
                OP_EV: begin
                    cpu_hit = 1'b1;
                    if (match) begin
                        wr_en    = 1'b1;
                        wr_state = ST_I;
                        wb_fire  = is_dirty(rd_state);
                    end
                end
                default: cpu_hit = 1'b1;
            endcase
            // dirty victim of another tag leaves before the fill
            if (start && !match && is_dirty(rd_state)) begin
                wb_fire  = 1'b1;
                wr_en    = 1'b1;
                wr_state = ST_I;
                wr_tag   = rd_tag;
            end
        end

        cpu_stall     = cpu_valid && !cpu_hit;
        line_state    = match ? rd_state : ST_I;
        bus_req_valid = (phase_q == PH_BUS);
        bus_req_cmd   = cmd_q;
        bus_req_addr  = cpu_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            cmd_q    <= BUS_RD;
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= wb_fire;
            if (wb_fire) begin
                wb_addr <= {rd_tag, idx};
                wb_data <= rd_data;
            end
            if (start) begin
                phase_q <= PH_BUS;
                cmd_q   <= start_cmd;
            end else if (phase_q == PH_BUS && bus_done) begin
                phase_q <= PH_IDLE;
            end
        end
    end

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
    import moesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int NLINES = 4,
    localparam int IDX_W = $clog2(NLINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_stall,
    output logic [2:0]        line_state,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_done,
    input  logic              bus_shared,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);

    line_state_e       rd_state, sn_state, wr_state, su_state;
    logic [TAG_W-1:0]  rd_tag, sn_tag, wr_tag;
    logic [DATA_W-1:0] rd_data, sn_data, wr_data;
    logic              wr_en, su_en;
    logic [IDX_W-1:0]  wr_idx;

    moesi_line_store #(.NLINES(NLINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (cpu_addr[IDX_W-1:0]),
        .rd_state (rd_state),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .sn_idx   (snp_addr[IDX_W-1:0]),
        .sn_state (sn_state),
        .sn_tag   (sn_tag),
        .sn_data  (sn_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_state (wr_state),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data),
        .su_en    (su_en),
        .su_idx   (snp_addr[IDX_W-1:0]),
        .su_state (su_state)
    );

    moesi_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_cmd    (snp_cmd),
        .snp_tag    (snp_addr[ADDR_W-1:IDX_W]),
        .sn_state   (sn_state),
        .sn_tag     (sn_tag),
        .sn_data    (sn_data),
        .snp_shared (snp_shared),
        .snp_supply (snp_supply),
        .snp_data   (snp_data),
        .su_en      (su_en),
        .su_state   (su_state)
    );

    moesi_req_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NLINES(NLINES)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .cpu_valid     (cpu_valid),
        .cpu_op        (cpu_op),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_rdata     (cpu_rdata),
        .cpu_hit       (cpu_hit),
        .cpu_stall     (cpu_stall),
        .line_state    (line_state),
        .rd_state      (rd_state),
        .rd_tag        (rd_tag),
        .rd_data       (rd_data),
        .bus_req_valid (bus_req_valid),
        .bus_req_cmd   (bus_req_cmd),
        .bus_req_addr  (bus_req_addr),
        .bus_done      (bus_done),
        .bus_shared    (bus_shared),
        .bus_rdata     (bus_rdata),
        .wb_valid      (wb_valid),
        .wb_addr       (wb_addr),
        .wb_data       (wb_data),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_state      (wr_state),
        .wr_tag        (wr_tag),
        .wr_data       (wr_data)
    );

endmodule

// File: rtl/moesi_line_checker.sv
module moesi_line_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_valid,
    input logic [1:0]        cpu_op,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_hit,
    input logic              cpu_stall,
    input logic [2:0]        line_state,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_done,
    input logic              wb_valid,
    input logic              snp_valid,
    input logic              snp_shared,
    input logic              snp_supply
);

    a_r1_state_legal: assert property (@(posedge clk) disable iff (rst)
        line_state <= 3'd4);

    a_r9_supply_needs_presence: assert property (@(posedge clk) disable iff (rst)
        snp_supply |-> snp_shared);

    a_r11_no_hit_while_bus: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> !cpu_hit);

    a_r3_silent_upgrade: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_op == 2'd1 && line_state == 3'd2 && !snp_valid)
        |-> (cpu_hit && !bus_req_valid));

    a_r3_becomes_modified: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_op == 2'd1 && line_state == 3'd2 && !snp_valid)
        |=> ((cpu_addr != $past(cpu_addr)) || line_state == 3'd4));

    a_r10_request_held: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && $past(bus_req_valid) && !$past(bus_done))
        |-> ($stable(bus_req_addr) && $stable(bus_req_cmd)));

    a_r8_bus_follows_stall: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req_valid) |-> $past(cpu_stall));

    a_r6_wb_follows_request: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(cpu_valid));

    a_r2_fill_ends_request: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_done) |=> !bus_req_valid);

    a_r7_no_supply_without_snoop: assert property (@(posedge clk) disable iff (rst)
        !snp_valid |-> !snp_shared);

endmodule

bind moesi_line_ctrl moesi_line_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_moesi_line_ctrl.sv
`timescale 1ns/1ps
module tb_moesi_line_ctrl;

    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          cv   [2];
    logic [1:0]    cop  [2];
    logic [AW-1:0] cad  [2];
    logic [DW-1:0] cwd  [2];
    logic [DW-1:0] crd  [2];
    logic          chit [2];
    logic          cstl [2];
    logic [2:0]    lst  [2];
    logic          brv  [2];
    logic [1:0]    bcmd [2];
    logic [AW-1:0] badr [2];
    logic          bdn  [2];
    logic          bsh  [2];
    logic [DW-1:0] brd  [2];
    logic          wbv  [2];
    logic [AW-1:0] wba  [2];
    logic [DW-1:0] wbd  [2];
    logic          sv   [2];
    logic [1:0]    scmd [2];
    logic [AW-1:0] sad  [2];
    logic          ssh  [2];
    logic          ssup [2];
    logic [DW-1:0] sdat [2];

    logic [DW-1:0] mem [256];

    moesi_line_ctrl dut (
        .clk(clk), .rst(rst), .cpu_valid(cv[0]), .cpu_op(cop[0]), .cpu_addr(cad[0]),
        .cpu_wdata(cwd[0]), .cpu_rdata(crd[0]), .cpu_hit(chit[0]), .cpu_stall(cstl[0]),
        .line_state(lst[0]), .bus_req_valid(brv[0]), .bus_req_cmd(bcmd[0]),
        .bus_req_addr(badr[0]), .bus_done(bdn[0]), .bus_shared(bsh[0]), .bus_rdata(brd[0]),
        .wb_valid(wbv[0]), .wb_addr(wba[0]), .wb_data(wbd[0]), .snp_valid(sv[0]),
        .snp_cmd(scmd[0]), .snp_addr(sad[0]), .snp_shared(ssh[0]), .snp_supply(ssup[0]),
        .snp_data(sdat[0]));

    moesi_line_ctrl peer (
        .clk(clk), .rst(rst), .cpu_valid(cv[1]), .cpu_op(cop[1]), .cpu_addr(cad[1]),
        .cpu_wdata(cwd[1]), .cpu_rdata(crd[1]), .cpu_hit(chit[1]), .cpu_stall(cstl[1]),
        .line_state(lst[1]), .bus_req_valid(brv[1]), .bus_req_cmd(bcmd[1]),
        .bus_req_addr(badr[1]), .bus_done(bdn[1]), .bus_shared(bsh[1]), .bus_rdata(brd[1]),
        .wb_valid(wbv[1]), .wb_addr(wba[1]), .wb_data(wbd[1]), .snp_valid(sv[1]),
        .snp_cmd(scmd[1]), .snp_addr(sad[1]), .snp_shared(ssh[1]), .snp_supply(ssup[1]),
        .snp_data(sdat[1]));

    // memory absorbs write-backs away from the active edge
    always @(negedge clk) begin
        for (int c = 0; c < 2; c++)
            if (wbv[c]) mem[wba[c]] <= wbd[c];
    end

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Runs one request on cache c at a negedge, modelling the bus for it.
    task automatic run_op(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                          output int nbus, output int nc2c, output bit ok);
        int o;
        o = 1 - c;
        cv[c] = 1'b1; cop[c] = op; cad[c] = a; cwd[c] = wd; cad[o] = a;
        nbus = 0; nc2c = 0; ok = 0; rd = '0;
        for (int k = 0; k < 20 && !ok; k++) begin
            #1;
            if (chit[c]) begin
                rd = crd[c];
                ok = 1;
                @(posedge clk); @(negedge clk);
                cv[c] = 1'b0;
            end else if (brv[c]) begin
                sv[o] = 1'b1; scmd[o] = bcmd[c]; sad[o] = badr[c];
                #1;
                bsh[c] = ssh[o];
                brd[c] = ssup[o] ? sdat[o] : mem[badr[c]];
                if (ssup[o]) nc2c++;
                nbus++;
                bdn[c] = 1'b1;
                @(posedge clk); @(negedge clk);
                sv[o] = 1'b0; bdn[c] = 1'b0;
            end else begin
                @(posedge clk); @(negedge clk);
            end
        end
        cv[c] = 1'b0;
    endtask

    typedef struct packed {
        logic [7:0]  rq;
        logic        c;
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic [15:0] rdata;
        logic [2:0]  st_self;
        logic [2:0]  st_other;
        logic [15:0] mem_exp;
        logic [1:0]  nbus;
        logic [1:0]  nc2c;
    } vec_t;

    // ops: 0 read, 1 write, 2 evict; states: I0 S1 E2 O3 M4
    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{8'd2,  1'b0, 2'd0, 8'h10, 16'h0000, 16'h0094, 3'd2, 3'd0, 16'h0094, 2'd1, 2'd0}, // R2 fill E
        '{8'd7,  1'b1, 2'd0, 8'h10, 16'h0000, 16'h0094, 3'd1, 3'd1, 16'h0094, 2'd1, 2'd0}, // R7 E->S, R2 fill S
        '{8'd8,  1'b0, 2'd1, 8'h10, 16'hAAAA, 16'h0000, 3'd4, 3'd0, 16'h0094, 2'd1, 2'd0}, // R8 S upgrade
        '{8'd4,  1'b1, 2'd0, 8'h10, 16'h0000, 16'hAAAA, 3'd1, 3'd3, 16'h0094, 2'd1, 2'd1}, // R4 M->O, no wb
        '{8'd6,  1'b1, 2'd2, 8'h10, 16'h0000, 16'h0000, 3'd0, 3'd3, 16'h0094, 2'd0, 2'd0}, // R6 S silent
        '{8'd5,  1'b1, 2'd0, 8'h10, 16'h0000, 16'hAAAA, 3'd1, 3'd3, 16'h0094, 2'd1, 2'd1}, // R5 O serves again
        '{8'd9,  1'b1, 2'd1, 8'h10, 16'h5555, 16'h0000, 3'd4, 3'd0, 16'h0094, 2'd1, 2'd1}, // R9 O supplies, invalid
        '{8'd4,  1'b0, 2'd0, 8'h10, 16'h0000, 16'h5555, 3'd1, 3'd3, 16'h0094, 2'd1, 2'd1}, // R4 peer M->O
        '{8'd6,  1'b1, 2'd2, 8'h10, 16'h0000, 16'h0000, 3'd0, 3'd1, 16'h5555, 2'd0, 2'd0}, // R6 O evict wb
        '{8'd7,  1'b1, 2'd0, 8'h10, 16'h0000, 16'h5555, 3'd1, 3'd1, 16'h5555, 2'd1, 2'd0}, // R7 S holder silent
        '{8'd8,  1'b0, 2'd1, 8'h10, 16'h1234, 16'h0000, 3'd4, 3'd0, 16'h5555, 2'd1, 2'd0}, // R8 peer S invalid
        '{8'd10, 1'b0, 2'd0, 8'h14, 16'h0000, 16'h00A0, 3'd2, 3'd0, 16'h00A0, 2'd1, 2'd0}, // R10 dirty victim
        '{8'd10, 1'b1, 2'd0, 8'h10, 16'h0000, 16'h1234, 3'd2, 3'd0, 16'h1234, 2'd1, 2'd0}, // R10 victim in mem
        '{8'd3,  1'b0, 2'd1, 8'h14, 16'h0F0F, 16'h0000, 3'd4, 3'd0, 16'h00A0, 2'd0, 2'd0}, // R3 silent E->M
        '{8'd10, 1'b1, 2'd1, 8'h21, 16'h7777, 16'h0000, 3'd4, 3'd0, 16'h00C7, 2'd1, 2'd0}, // R10 write miss
        '{8'd4,  1'b0, 2'd0, 8'h21, 16'h0000, 16'h7777, 3'd1, 3'd3, 16'h00C7, 2'd1, 2'd1}, // R4 c2c
        '{8'd8,  1'b0, 2'd1, 8'h21, 16'h0101, 16'h0000, 3'd4, 3'd0, 16'h00C7, 2'd1, 2'd1}, // R8 upgrade vs O
        '{8'd6,  1'b0, 2'd2, 8'h14, 16'h0000, 16'h0000, 3'd0, 3'd0, 16'h0F0F, 2'd0, 2'd0}, // R6 M evict wb
        '{8'd9,  1'b1, 2'd1, 8'h21, 16'h2222, 16'h0000, 3'd4, 3'd0, 16'h00C7, 2'd1, 2'd1}, // R9 RdX vs M
        '{8'd11, 1'b1, 2'd0, 8'h21, 16'h0000, 16'h2222, 3'd4, 3'd0, 16'h00C7, 2'd0, 2'd0}, // R11 read hit
        '{8'd6,  1'b0, 2'd2, 8'h14, 16'h0000, 16'h0000, 3'd0, 3'd0, 16'h0F0F, 2'd0, 2'd0}  // R6 absent evict
    };

    initial begin
        #500000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] rd;
        int nb, nc;
        bit ok;
        string rq;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3 + 100);
        for (int c = 0; c < 2; c++) begin
            cv[c] = 0; cop[c] = 0; cad[c] = 0; cwd[c] = 0;
            bdn[c] = 0; bsh[c] = 0; brd[c] = 0; sv[c] = 0; scmd[c] = 0; sad[c] = 0;
        end
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            cad[0] = 8'(a); cad[1] = 8'(a);
            #1;
            check("R1", "reset state dut", {29'd0, lst[0]}, 32'd0);
            check("R1", "reset state peer", {29'd0, lst[1]}, 32'd0);
        end
        check("R1", "reset bus idle", {31'd0, brv[0]}, 32'd0);
        check("R1", "reset wb idle", {31'd0, wbv[0]}, 32'd0);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            rq = $sformatf("R%0d vec%0d", VECS[i].rq, i);
            run_op(int'(VECS[i].c), VECS[i].op, VECS[i].addr, VECS[i].wdata, rd, nb, nc, ok);
            cad[0] = VECS[i].addr; cad[1] = VECS[i].addr;
            #1;
            check(rq, "completed", {31'd0, ok}, 32'd1);
            if (VECS[i].op == 2'd0) check(rq, "read data", {16'd0, rd}, {16'd0, VECS[i].rdata});
            check(rq, "requester state", {29'd0, lst[VECS[i].c]}, {29'd0, VECS[i].st_self});
            check(rq, "other state", {29'd0, lst[!VECS[i].c]}, {29'd0, VECS[i].st_other});
            check(rq, "memory word", {16'd0, mem[VECS[i].addr]}, {16'd0, VECS[i].mem_exp});
            check(rq, "bus transactions", 32'(nb), {30'd0, VECS[i].nbus});
            check(rq, "cache supplies", 32'(nc), {30'd0, VECS[i].nc2c});
            @(negedge clk);
        end

        // R11 directed: miss stalls in its first cycle, then completes
        cv[0] = 1'b1; cop[0] = 2'd0; cad[0] = 8'h33; cad[1] = 8'h33;
        #1;
        check("R11", "stall on miss", {31'd0, cstl[0]}, 32'd1);
        check("R11", "no hit on miss", {31'd0, chit[0]}, 32'd0);
        run_op(0, 2'd0, 8'h33, 16'h0, rd, nb, nc, ok);
        check("R11", "miss data", {16'd0, rd}, 32'd253);
        cad[0] = 8'h33;
        #1;
        check("R2", "lone fill exclusive", {29'd0, lst[0]}, 32'd2);

        finish_run();
    end

endmodule